// File: doc/BRIEF.md
# Permuted Averaging Majority Approximator

This block gives a fast, approximate answer to the question "are at least five of these nine bits set?". The question comes up when an encoder chooses whether to invert a bus word. The inputs are the eight per-line toggle flags plus the previous control flag. Flipping the word is only worthwhile when most lines would toggle. An exact popcount compare is slow. A wrong vote still encodes correctly and only costs a few extra toggles, so an approximation is acceptable here.

The core element is a four-level binary tree of fifteen 2-input NAND gates. Its leaves read overlapping neighbour pairs of the inputs. Three copies of that tree evaluate in parallel:

- one copy sees the inputs unchanged;
- the other two see the inputs under two fixed reorderings.

A four-NAND 2-of-3 vote merges the three tree results. Because the three copies err on different patterns, the vote cancels most of the mistakes of any single tree. The result of the unpermuted tree is also offered on a second output for users who prefer the shallower path.

The datapath is purely combinational. It sits inside a valid/ready pass-through:

- A word is consumed when `in_valid` and `in_ready` are both high.
- `in_ready` follows `out_ready` in the same cycle, so back-pressure from the consumer stalls the producer directly.
- `out_valid` mirrors `in_valid`.
- The producer must hold `in_bits` stable while `in_valid` is high and `in_ready` is low.

Top module: `avg_maj_vote`

## Requirements
- R1: `single_out` equals T(x), where x = `in_bits` and N(a,b) = NOT(a AND b). T is built in four levels:
  - Leaves: N(x0,x1), N(x2,x3), N(x1,x2), N(x3,x4), N(x4,x5), N(x6,x7), N(x5,x6), N(x7,x8).
  - The second level combines these leaves in consecutive pairs in that order.
  - The third level combines the first two second-level results, then the last two.
  - The output is N of the two third-level results.
- R2: Over all 512 input patterns, `single_out` differs from exact majority (popcount of 5 or more) on exactly 93 patterns.
- R3: Summing |2*popcount-9| over the patterns where `single_out` differs from exact majority gives exactly 113.
- R4: `vote_out` is the 2-of-3 majority of three tree results:
  - T(x);
  - T(a), where a[k] for k=0..8 takes x4,x3,x5,x8,x0,x6,x2,x1,x7 in that order;
  - T(b), where b[k] takes x1,x5,x8,x2,x4,x7,x6,x3,x0 in that order.
- R5: Over all 512 input patterns, `vote_out` differs from exact majority on exactly 39 patterns.
- R6: An all-zero input gives 0 on both outputs, and an all-ones input gives 1 on both outputs.
- R7: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in every cycle, whatever the data.
- R8: With parameter SHOW_SINGLE set to 0, `single_out` is held at 0. With the default of 1, it carries the R1 result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_valid | input | 1 | Producer presents a toggle vector |
| in_ready | output | 1 | Block can accept; follows out_ready |
| in_bits | input | 9 | Toggle vector to be voted on |
| out_valid | output | 1 | Vote result is presented |
| out_ready | input | 1 | Consumer accepts the result |
| vote_out | output | 1 | Averaged 2-of-3 approximate majority |
| single_out | output | 1 | Result of the unpermuted tree alone |

## Verification
Some properties can be checked on every evaluation, and assertions inside the RTL do so:

- The vote stage agrees with a 2-of-3 count of its three inputs.
- A unanimous set of trees forces the vote.
- Each reordering preserves the number of set bits.
- The tree resolves the all-zero and all-ones patterns correctly.

The exact error totals of 93 and 39 and the added toggle cost of 113 are properties of the whole truth table. Only the bench's exhaustive sweep can show them. The same holds for the pass-through handshake under random stalls.

// File: rtl/avg_vote_pkg.sv
package avg_vote_pkg;
  localparam int unsigned VOTE_W = 9;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned PERM_W = VOTE_W * IDX_W;

  typedef logic [VOTE_W-1:0] vec_t;
  typedef logic [PERM_W-1:0] perm_t;

  // position k of a reordered vector reads source bit perm[k*IDX_W +: IDX_W]
  localparam perm_t PERM_IDENT = 36'h8_7_6_5_4_3_2_1_0;
  localparam perm_t PERM_A     = 36'h7_1_2_6_0_8_5_3_4;
  localparam perm_t PERM_B     = 36'h0_3_6_7_4_2_8_5_1;

  function automatic logic nand2(input logic a, input logic b);
    return ~(a & b);
  endfunction
endpackage

// File: rtl/bit_reorder.sv
module bit_reorder
  import avg_vote_pkg::*;
#(
  parameter perm_t ORDER = PERM_IDENT
) (
  input  vec_t src,
  output vec_t dst
);
  for (genvar k = 0; k < int'(VOTE_W); k++) begin : g_lane
    localparam int SRC_IDX = int'(ORDER[k*IDX_W +: IDX_W]);
    assign dst[k] = src[SRC_IDX];
  end

  always_comb begin
    // R4
    reorder_weight_chk: assert ($countones(dst) == $countones(src))
      else $error("reorder changed the number of set bits");
  end
endmodule

// File: rtl/nand_tree9.sv
module nand_tree9
  import avg_vote_pkg::*;
(
  input  vec_t x,
  output logic y
);
  logic [7:0] lvl1;
  logic [3:0] lvl2;
  logic [1:0] lvl3;

  // leaves on overlapping neighbour pairs, grouped as the upper levels consume them
  assign lvl1[0] = nand2(x[0], x[1]);
  assign lvl1[1] = nand2(x[2], x[3]);
  assign lvl1[2] = nand2(x[1], x[2]);
  assign lvl1[3] = nand2(x[3], x[4]);
  assign lvl1[4] = nand2(x[4], x[5]);
  assign lvl1[5] = nand2(x[6], x[7]);
  assign lvl1[6] = nand2(x[5], x[6]);
  assign lvl1[7] = nand2(x[7], x[8]);

  for (genvar i = 0; i < 4; i++) begin : g_l2
    assign lvl2[i] = nand2(lvl1[2*i], lvl1[2*i+1]);
  end
  for (genvar j = 0; j < 2; j++) begin : g_l3
    assign lvl3[j] = nand2(lvl2[2*j], lvl2[2*j+1]);
  end
  assign y = nand2(lvl3[0], lvl3[1]);

  always_comb begin
    // R6
    tree_zero_chk: assert (!(x == '0) || (y == 1'b0))
      else $error("tree did not vote 0 on all-zero input");
    // R6
    tree_ones_chk: assert (!(x == '1) || (y == 1'b1))
      else $error("tree did not vote 1 on all-ones input");
  end
endmodule

// File: rtl/vote3_nand.sv
module vote3_nand
  import avg_vote_pkg::*;
(
  input  logic [2:0] v,
  output logic       m
);
  logic n01, n12, n02;
  assign n01 = nand2(v[0], v[1]);
  assign n12 = nand2(v[1], v[2]);
  assign n02 = nand2(v[0], v[2]);
  assign m   = ~(n01 & n12 & n02);

  always_comb begin
    // R4
    vote_count_chk: assert (m == ($countones(v) >= 2))
      else $error("vote stage disagrees with 2-of-3 count");
  end
endmodule

// File: rtl/avg_maj_vote.sv
module avg_maj_vote
  import avg_vote_pkg::*;
#(
  parameter bit SHOW_SINGLE = 1'b1
) (
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VOTE_W-1:0] in_bits,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              vote_out,
  output logic              single_out
);
  localparam int unsigned COPIES = 3;
  localparam perm_t ORDERS [COPIES] = '{PERM_IDENT, PERM_A, PERM_B};

  vec_t              seen [COPIES];
  logic [COPIES-1:0] tree_y;

  for (genvar c = 0; c < int'(COPIES); c++) begin : g_copy
    bit_reorder #(.ORDER(ORDERS[c])) u_ord (.src(in_bits), .dst(seen[c]));
    nand_tree9 u_tree (.x(seen[c]), .y(tree_y[c]));
  end

  vote3_nand u_vote (.v(tree_y), .m(vote_out));

  if (SHOW_SINGLE) begin : g_single
    assign single_out = tree_y[0];
  end else begin : g_nosingle
    assign single_out = 1'b0;
  end

  // R7 pass-through handshake
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  always_comb begin
    // R4
    unanimous_chk: assert (!((tree_y == '0) || (tree_y == '1)) || (vote_out == tree_y[0]))
      else $error("unanimous trees did not set the vote");
  end
endmodule

// File: tb/sim_avg_maj_vote.sv
module sim_avg_maj_vote;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid, in_ready, out_valid, out_ready, vote_out, single_out;
  logic [8:0] in_bits;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  avg_maj_vote u0 (
    .in_valid(in_valid), .in_ready(in_ready), .in_bits(in_bits),
    .out_valid(out_valid), .out_ready(out_ready),
    .vote_out(vote_out), .single_out(single_out)
  );

  function automatic logic nd(input logic a, input logic b);
    return !(a && b);
  endfunction

  function automatic logic ref_tree(input logic [8:0] x);
    logic p, q, r, s;
    p = nd(nd(x[0], x[1]), nd(x[2], x[3]));
    q = nd(nd(x[1], x[2]), nd(x[3], x[4]));
    r = nd(nd(x[4], x[5]), nd(x[6], x[7]));
    s = nd(nd(x[5], x[6]), nd(x[7], x[8]));
    return nd(nd(p, q), nd(r, s));
  endfunction

  function automatic logic [8:0] reorder(input logic [8:0] x, input int which);
    int ta [9] = '{4, 3, 5, 8, 0, 6, 2, 1, 7};
    int tb [9] = '{1, 5, 8, 2, 4, 7, 6, 3, 0};
    logic [8:0] r;
    for (int k = 0; k < 9; k++) r[k] = (which == 0) ? x[ta[k]] : x[tb[k]];
    return r;
  endfunction

  function automatic logic ref_vote(input logic [8:0] x);
    int s;
    s = int'(ref_tree(x)) + int'(ref_tree(reorder(x, 0))) + int'(ref_tree(reorder(x, 1)));
    return s >= 2;
  endfunction

  function automatic int pop9(input logic [8:0] x);
    int c = 0;
    for (int k = 0; k < 9; k++) c += int'(x[k]);
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic apply(input logic [8:0] x, input logic v, input logic r);
    @(negedge clk);
    in_bits = x; in_valid = v; out_ready = r;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int err_single, err_vote, cost_single;
    logic mj;
    void'($urandom(32'd4242));
    in_bits = '0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R6 and R7 at the idle starting point
    apply(9'h000, 1'b0, 1'b0);
    check("R6 zero vote", vote_out, 0);
    check("R6 zero single", single_out, 0);
    check("R7 idle valid", out_valid, 0);
    check("R7 idle ready", in_ready, 0);
    apply(9'h1FF, 1'b1, 1'b1);
    check("R6 ones vote", vote_out, 1);
    check("R6 ones single", single_out, 1);
    check("R7 valid", out_valid, 1);
    check("R7 ready", in_ready, 1);

    // directed: single set bits and single cleared bits
    for (int k = 0; k < 9; k++) begin
      apply(9'(1 << k), 1'b1, 1'b0);
      check("R4 one-hot vote", vote_out, ref_vote(9'(1 << k)));
      check("R1 one-hot single", single_out, ref_tree(9'(1 << k)));
      apply(~9'(1 << k), 1'b0, 1'b1);
      check("R4 one-cold vote", vote_out, ref_vote(~9'(1 << k)));
      check("R1 one-cold single", single_out, ref_tree(~9'(1 << k)));
    end

    // exhaustive sweep with random handshake
    err_single = 0; err_vote = 0; cost_single = 0;
    for (int i = 0; i < 512; i++) begin
      logic v, r;
      v = 1'($urandom);
      r = 1'($urandom);
      apply(9'(i), v, r);
      mj = pop9(9'(i)) >= 5;
      check("R1 tree", single_out, ref_tree(9'(i)));
      check("R4 vote", vote_out, ref_vote(9'(i)));
      check("R7 valid", out_valid, v);
      check("R7 ready", in_ready, r);
      check("R8 single shown", single_out, ref_tree(9'(i)));
      if (single_out != mj) begin
        err_single++;
        cost_single += (2 * pop9(9'(i)) > 9) ? 2 * pop9(9'(i)) - 9 : 9 - 2 * pop9(9'(i));
      end
      if (vote_out != mj) err_vote++;
    end
    check("R2 single errors", err_single, 93);
    check("R3 added toggles", cost_single, 113);
    check("R5 vote errors", err_vote, 39);

    // random vectors
    for (int n = 0; n < 300; n++) begin
      logic [8:0] x;
      x = 9'($urandom);
      apply(x, 1'b1, 1'($urandom));
      check("R4 random vote", vote_out, ref_vote(x));
      check("R1 random single", single_out, ref_tree(x));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule